// File: doc/BRIEF.md
# Undervoltage Reset Deglitch Filter

This block turns two digitized supply comparator flags into a filtered, active-low reset for the logic that depends on a stable supply: the watchdog, the transmit timeout logic and the serial-port datapath. The control registers of the serial port are not reset by it. One flag reports that the supply has climbed above the upper (release) threshold. The other reports that it has dropped under the lower (assert) threshold. The two flags come from separate comparators, so the gap between the thresholds acts as hysteresis.

Each flag first passes through a two-flop synchronizer. Each direction then has its own dwell counter, and the two counters take separate tick counts. The reset is asserted only after the supply has stayed low without a break for longer than the assert delay. It is released only after the supply has stayed good without a break for longer than the reset duration. A short assert delay paired with a longer release hold gives the two directions asymmetric qualification times. Each change of the output is marked by a one-cycle event pulse. A two-bit threshold selection code passes straight through the block to the comparator trim.

Top module: `uvr_reset_filter`

## Requirements
- R1: While the power-on reset input is low, and on the first cycles after it is released, the reset output is low (asserted) and both event pulses are low.
- R2: With the output low, the reset output goes high once the above-threshold flag has been 1 (and the below-threshold flag 0) for `release_dly + 1` consecutive clock samples. The output changes on rising edge `release_dly + 3`, where edge 1 is the first edge that samples the flag at 1 (two synchronizer stages plus the dwell).
- R3: With the output high, the reset output goes low once the below-threshold flag has been 1 for `assert_dly + 1` consecutive clock samples. The output changes on rising edge `assert_dly + 3`, counted as in R2.
- R4: A below-threshold pulse lasting only `assert_dly` clock samples leaves the output high, and no assert event is produced.
- R5: Any single sample on which the qualifying flag drops out restarts that direction's dwell from zero. The full `delay + 1` uninterrupted samples are then needed again.
- R6: While both flags are 0 (supply inside the hysteresis band), the output keeps its current state and no event is produced.
- R7: When both flags read 1, the below-threshold flag wins. The output is not released, and a high output is asserted after the assert dwell.
- R8: `evt_release` is high for exactly one cycle, in the cycle in which the output has just gone from low to high. `evt_assert` behaves the same way for a change from high to low. The two are never high together.
- R9: `thr_sel_o` equals `thr_sel_i` for all four code values 0 to 3, without delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| sup_above_i | input | 1 | Comparator flag: supply above release threshold (asynchronous) |
| sup_below_i | input | 1 | Comparator flag: supply below assert threshold (asynchronous) |
| assert_dly | input | CNT_W | Assert dwell in clock ticks |
| release_dly | input | CNT_W | Release dwell (reset duration) in clock ticks |
| thr_sel_i | input | 2 | Threshold level selection code |
| thr_sel_o | output | 2 | Threshold selection passed to the comparator trim |
| rst_out_n | output | 1 | Filtered reset, low = asserted |
| evt_assert | output | 1 | One-cycle pulse when the reset becomes asserted |
| evt_release | output | 1 | One-cycle pulse when the reset becomes released |

## Verification
The bench builds the block with `CNT_W = 4`. This puts every delay setting from 0 to 15 within reach, for both the assert and the release direction. For each setting it checks the exact edge on which the output moves, a dip one sample too short, and a dwell broken by one sample. The small counter width also lets the largest delay, where the counter sits at its top value, be covered next to the zero-delay case. The conflict case with both flags high and the hold inside the hysteresis band are run in both output states.

// File: rtl/uvr_pkg.sv
package uvr_pkg;

  // Output state; the encoding equals the level of the active-low reset pin.
  typedef enum logic {
    UVR_ASSERTED = 1'b0,
    UVR_RELEASED = 1'b1
  } uvr_state_e;

  localparam int UVR_THR_W = 2;

endpackage

// File: rtl/uvr_flag_sync.sv
module uvr_flag_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);

  logic [WIDTH-1:0] stage_q [STAGES];
  logic [WIDTH-1:0] stage_d [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_comb stage_d[s] = async_i;
    end else begin : g_chain
      always_comb stage_d[s] = stage_q[s-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage_q[s] <= '0;
      end else begin
        stage_q[s] <= stage_d[s];
      end
    end
  end

  assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/uvr_dwell_counter.sv
module uvr_dwell_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cond_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             fire_o
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;
  logic             reached;

  // The condition has held for limit+1 samples once the count reaches the limit.
  assign reached = (cnt_q >= limit_i);
  assign fire_o  = cond_i && reached;

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (!cond_i) begin
      cnt_en = (cnt_q != '0);
      cnt_d  = '0;
    end else if (!reached) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  AST_CNT_CLEAR_ON_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    !cond_i |=> (cnt_q == '0)); // R5

endmodule

// File: rtl/uvr_reset_state.sv
module uvr_reset_state
  import uvr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic fire_release_i,
  input  logic fire_assert_i,
  output logic rst_out_n,
  output logic evt_assert_o,
  output logic evt_release_o
);

  uvr_state_e state_q;
  uvr_state_e state_d;
  logic       evt_a_d;
  logic       evt_r_d;
  logic       evt_a_q;
  logic       evt_r_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      UVR_ASSERTED: if (fire_release_i) state_d = UVR_RELEASED;
      UVR_RELEASED: if (fire_assert_i)  state_d = UVR_ASSERTED;
      default:      state_d = UVR_ASSERTED;
    endcase
    evt_r_d = (state_q == UVR_ASSERTED) && (state_d == UVR_RELEASED);
    evt_a_d = (state_q == UVR_RELEASED) && (state_d == UVR_ASSERTED);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= UVR_ASSERTED;
      evt_a_q <= 1'b0;
      evt_r_q <= 1'b0;
    end else begin
      state_q <= state_d;
      evt_a_q <= evt_a_d;
      evt_r_q <= evt_r_d;
    end
  end

  assign rst_out_n     = state_q;
  assign evt_assert_o  = evt_a_q;
  assign evt_release_o = evt_r_q;

  AST_EVT_REL_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_out_n) |-> evt_release_o); // R8
  AST_EVT_ASR_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rst_out_n) |-> evt_assert_o); // R8
  AST_EVT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    evt_release_o |=> !evt_release_o); // R8
  AST_EVT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(evt_release_o && evt_assert_o)); // R8

endmodule

// File: rtl/uvr_reset_filter.sv
module uvr_reset_filter
  import uvr_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 por_n,
  input  logic                 sup_above_i,
  input  logic                 sup_below_i,
  input  logic [CNT_W-1:0]     assert_dly,
  input  logic [CNT_W-1:0]     release_dly,
  input  logic [UVR_THR_W-1:0] thr_sel_i,
  output logic [UVR_THR_W-1:0] thr_sel_o,
  output logic                 rst_out_n,
  output logic                 evt_assert,
  output logic                 evt_release
);

  localparam int FLAG_N = 2;
  localparam int IDX_ABOVE = 0;
  localparam int IDX_BELOW = 1;

  logic [FLAG_N-1:0] flags_async;
  logic [FLAG_N-1:0] flags_sync;
  logic              s_above;
  logic              s_below;
  logic              cond_release;
  logic              cond_assert;
  logic              fire_release;
  logic              fire_assert;

  assign flags_async[IDX_ABOVE] = sup_above_i;
  assign flags_async[IDX_BELOW] = sup_below_i;

  uvr_flag_sync #(
    .WIDTH  (FLAG_N),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk     (clk),
    .rst_n   (por_n),
    .async_i (flags_async),
    .sync_o  (flags_sync)
  );

  assign s_above = flags_sync[IDX_ABOVE];
  assign s_below = flags_sync[IDX_BELOW];

  // The low-supply flag takes priority when both read high.
  assign cond_release = s_above && !s_below && (rst_out_n == UVR_ASSERTED);
  assign cond_assert  = s_below && (rst_out_n == UVR_RELEASED);

  uvr_dwell_counter #(.CNT_W(CNT_W)) u_rel_cnt (
    .clk     (clk),
    .rst_n   (por_n),
    .cond_i  (cond_release),
    .limit_i (release_dly),
    .fire_o  (fire_release)
  );

  uvr_dwell_counter #(.CNT_W(CNT_W)) u_asr_cnt (
    .clk     (clk),
    .rst_n   (por_n),
    .cond_i  (cond_assert),
    .limit_i (assert_dly),
    .fire_o  (fire_assert)
  );

  uvr_reset_state u_state (
    .clk            (clk),
    .rst_n          (por_n),
    .fire_release_i (fire_release),
    .fire_assert_i  (fire_assert),
    .rst_out_n      (rst_out_n),
    .evt_assert_o   (evt_assert),
    .evt_release_o  (evt_release)
  );

  assign thr_sel_o = thr_sel_i;

  AST_RELEASE_QUALIFIED: assert property (@(posedge clk) disable iff (!por_n)
    $rose(rst_out_n) |-> ($past(s_above) && !$past(s_below))); // R2
  AST_ASSERT_QUALIFIED: assert property (@(posedge clk) disable iff (!por_n)
    $fell(rst_out_n) |-> $past(s_below)); // R3
  AST_BAND_HOLD: assert property (@(posedge clk) disable iff (!por_n)
    (!s_above && !s_below) |=> $stable(rst_out_n)); // R6
  AST_BELOW_BLOCKS_RELEASE: assert property (@(posedge clk) disable iff (!por_n)
    (s_below && !rst_out_n) |=> !rst_out_n); // R7

endmodule

// File: tb/uvr_reset_filter_test.sv
`timescale 1ns/1ps
module uvr_reset_filter_test;

  localparam int CW   = 4;
  localparam int DMAX = (1 << CW) - 1;

  logic          clk = 1'b0;
  logic          por_n;
  logic          above;
  logic          below;
  logic [CW-1:0] a_dly;
  logic [CW-1:0] r_dly;
  logic [1:0]    thr_in;
  logic [1:0]    thr_out;
  logic          rst_n_o;
  logic          ev_a;
  logic          ev_r;

  int total = 0;
  int bad   = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  uvr_reset_filter #(.CNT_W(CW), .SYNC_STAGES(2)) uut (
    .clk         (clk),
    .por_n       (por_n),
    .sup_above_i (above),
    .sup_below_i (below),
    .assert_dly  (a_dly),
    .release_dly (r_dly),
    .thr_sel_i   (thr_in),
    .thr_sel_o   (thr_out),
    .rst_out_n   (rst_n_o),
    .evt_assert  (ev_a),
    .evt_release (ev_r)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      bad   = bad + 1;
      total = total + 1;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d at t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  // Bring the output low quickly, then leave the supply inside the band.
  task automatic go_low();
    a_dly = '0; above = 1'b0; below = 1'b1;
    for (int i = 0; i < 10 && rst_n_o; i++) tick();
    below = 1'b0;
    ticks(4);
    chk(rst_n_o == 1'b0, "setup-low", rst_n_o, 0);
  endtask

  task automatic go_high();
    r_dly = '0; below = 1'b0; above = 1'b1;
    for (int i = 0; i < 10 && !rst_n_o; i++) tick();
    above = 1'b0;
    ticks(4);
    chk(rst_n_o == 1'b1, "setup-high", rst_n_o, 1);
  endtask

  // Flag already applied at this negedge; output must move on edge d+3.
  task automatic watch(input bit rise, input int d, input string req);
    for (int n = 1; n <= d + 3; n++) begin
      tick();
      if (n < d + 3) begin
        chk(rst_n_o == !rise, req, rst_n_o, !rise);
        chk((rise ? ev_r : ev_a) == 1'b0, req, rise ? ev_r : ev_a, 0);
      end else begin
        chk(rst_n_o == rise, req, rst_n_o, rise);
        chk((rise ? ev_r : ev_a) == 1'b1, {req, "/R8"}, rise ? ev_r : ev_a, 1);
        chk((rise ? ev_a : ev_r) == 1'b0, {req, "/R8"}, rise ? ev_a : ev_r, 0);
      end
    end
    tick();
    chk((rise ? ev_r : ev_a) == 1'b0, "R8 pulse width", rise ? ev_r : ev_a, 0);
    chk(rst_n_o == rise, req, rst_n_o, rise);
  endtask

  initial begin
    por_n = 1'b0; above = 1'b0; below = 1'b0;
    a_dly = '0; r_dly = '0; thr_in = 2'd0;
    ticks(3);
    // R1: reset state during and just after power-on reset
    chk(rst_n_o == 1'b0, "R1", rst_n_o, 0);
    chk(ev_a == 1'b0 && ev_r == 1'b0, "R1", {ev_a, ev_r}, 0);
    por_n = 1'b1;
    ticks(3);
    chk(rst_n_o == 1'b0, "R1", rst_n_o, 0);
    chk(ev_a == 1'b0 && ev_r == 1'b0, "R1", {ev_a, ev_r}, 0);

    // R9: threshold code passthrough
    for (int c = 0; c < 4; c++) begin
      thr_in = 2'(c);
      #1;
      chk(thr_out == 2'(c), "R9", thr_out, c);
    end

    // R2: release timing for every delay
    for (int d = 0; d <= DMAX; d++) begin
      if (rst_n_o) go_low();
      r_dly = CW'(d); above = 1'b1;
      watch(1'b1, d, "R2");
      above = 1'b0;
      ticks(3);
    end

    // R3: assert timing for every delay
    for (int d = 0; d <= DMAX; d++) begin
      if (!rst_n_o) go_high();
      a_dly = CW'(d); below = 1'b1;
      watch(1'b0, d, "R3");
      below = 1'b0;
      ticks(3);
    end

    // R4: dip one sample too short is ignored
    for (int d = 1; d <= DMAX; d++) begin
      if (!rst_n_o) go_high();
      a_dly = CW'(d); below = 1'b1;
      ticks(d);
      below = 1'b0;
      for (int n = 0; n < d + 5; n++) begin
        tick();
        chk(rst_n_o == 1'b1, "R4", rst_n_o, 1);
        chk(ev_a == 1'b0, "R4", ev_a, 0);
      end
    end

    // R5: interrupted dwell restarts, both directions
    for (int d = 1; d <= DMAX; d++) begin
      if (rst_n_o) go_low();
      r_dly = CW'(d); above = 1'b1;
      ticks(d);
      above = 1'b0;
      tick();
      above = 1'b1;
      watch(1'b1, d, "R5 release");
      above = 1'b0;
      a_dly = CW'(d); below = 1'b1;
      ticks(d);
      below = 1'b0;
      tick();
      below = 1'b1;
      watch(1'b0, d, "R5 assert");
      below = 1'b0;
      ticks(3);
    end

    // R6: hold inside the hysteresis band in both states
    go_low();
    for (int n = 0; n < 40; n++) begin
      tick();
      chk(rst_n_o == 1'b0 && !ev_a && !ev_r, "R6 low", rst_n_o, 0);
    end
    go_high();
    for (int n = 0; n < 40; n++) begin
      tick();
      chk(rst_n_o == 1'b1 && !ev_a && !ev_r, "R6 high", rst_n_o, 1);
    end

    // R7: both flags high
    go_low();
    r_dly = '0; above = 1'b1; below = 1'b1;
    for (int n = 0; n < 40; n++) begin
      tick();
      chk(rst_n_o == 1'b0 && !ev_r, "R7 no release", rst_n_o, 0);
    end
    above = 1'b0; below = 1'b0;
    ticks(3);
    go_high();
    a_dly = CW'(3); above = 1'b1; below = 1'b1;
    watch(1'b0, 3, "R7 assert");
    above = 1'b0; below = 1'b0;
    ticks(3);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule